// File: doc/BRIEF.md
# Processor Status Flag Register

This block is the 8-bit condition and control register of a small 8-bit CPU core. It holds four result flags: carry, zero, overflow and negative. It also holds two control flags: interrupt mask and decimal arithmetic. The execution unit writes the result flags through a per-flag enable mask. The instruction decoder sets or clears carry, mask or decimal through a small command code. The interrupt sequencer raises a strobe when it accepts an interrupt. Restoring the register from the stack is a single full-byte load.

The register drives the packed byte used for stack saves and the separate flag lines used by conditional branches. It also drives a validity line. This line drops when an add or subtract ran in decimal mode, because the zero, overflow and negative results of such an operation carry no meaning. A combinational gate combines the interrupt mask with the pending hardware request and the software break request to decide whether an interrupt is taken.

Top module: `psr_status_reg`

## Requirements
- R1: A synchronous active-high reset sets the mask flag (bit 2) to 1, clears C (bit 0), Z (bit 1), V (bit 6) and N (bit 7), and sets `flags_valid` to 1.
- R2: Reset leaves the decimal flag (bit 3) unchanged. It changes only through a load or a decimal set/clear command.
- R3: Bits 4 and 5 of `status_byte` always read as the parameter `RSVD_FILL`, which defaults to 2'b11, whatever is loaded.
- R4: Each bit of `alu_we` at position 0, 1, 6 or 7 copies the same bit of `alu_flags` into C, Z, V or N on the clock edge. Enable bits 2 to 5 have no effect.
- R5: `cmd` codes: 0 none, 1 set C, 2 clear C, 3 set mask, 4 clear mask, 5 set decimal, 6 clear decimal, 7 none. No code touches Z, V or N.
- R6: When a command and an ALU enable target the carry flag in the same cycle, the command decides the new value.
- R7: `int_accept` forces the mask flag to 1, overriding a mask-clear command in the same cycle.
- R8: `load_en` copies bits 7, 6 and 3 to 0 of `load_byte` into the flags and sets `flags_valid` to 1. It overrides every other update except reset.
- R9: An ALU update that enables any of Z, V or N with `alu_decimal_op` high while the decimal flag is 1 clears `flags_valid`. Any other ALU update that enables Z, V or N sets it again.
- R10: `int_take` is high when `brk_req` is high, or when `irq_req` is high and the mask flag is 0, in the same cycle.
- R11: `flag_c`, `flag_z`, `flag_i`, `flag_d`, `flag_v` and `flag_n` always equal bits 0, 1, 2, 3, 6 and 7 of `status_byte`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_we | input | 8 | Per-flag ALU write enables, aligned to status bit positions |
| alu_flags | input | 8 | ALU flag values, aligned to status bit positions |
| alu_decimal_op | input | 1 | The current ALU update comes from an add or subtract |
| cmd | input | 3 | Single-flag set/clear command code |
| int_accept | input | 1 | Interrupt accepted strobe |
| load_en | input | 1 | Full-byte restore strobe |
| load_byte | input | 8 | Byte to restore |
| irq_req | input | 1 | Pending hardware interrupt request |
| brk_req | input | 1 | Software break request |
| status_byte | output | 8 | Packed status register |
| flag_c | output | 1 | Carry |
| flag_z | output | 1 | Zero |
| flag_i | output | 1 | Interrupt mask |
| flag_d | output | 1 | Decimal mode |
| flag_v | output | 1 | Overflow |
| flag_n | output | 1 | Negative |
| flags_valid | output | 1 | Z, V and N are meaningful |
| int_take | output | 1 | Interrupt will be taken |

## Verification
The assertions assume that reset is not asserted in the cycle after a load or an idle cycle. This is what allows them to compare the register with its previous value. They also assume that `cmd` always holds one of the eight listed codes. The stimulus keeps to this: reset is only raised in dedicated reset phases that start from idle inputs. No ALU update with `alu_decimal_op` high is issued until the decimal flag has been given a known value by a load or a command.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int PSR_W = 8;
  localparam int BIT_C = 0;
  localparam int BIT_Z = 1;
  localparam int BIT_I = 2;
  localparam int BIT_D = 3;
  localparam int BIT_R_LO = 4;
  localparam int BIT_R_HI = 5;
  localparam int BIT_V = 6;
  localparam int BIT_N = 7;

  // flags the execution unit may write
  localparam logic [PSR_W-1:0] ALU_MASK = 8'b1100_0011;
  // flags whose update marks validity
  localparam logic [PSR_W-1:0] RESULT_MASK = 8'b1100_0010;

  typedef enum logic [2:0] {
    CMD_NONE  = 3'd0,
    CMD_SET_C = 3'd1,
    CMD_CLR_C = 3'd2,
    CMD_SET_I = 3'd3,
    CMD_CLR_I = 3'd4,
    CMD_SET_D = 3'd5,
    CMD_CLR_D = 3'd6,
    CMD_SPARE = 3'd7
  } flag_cmd_e;
endpackage

// File: rtl/psr_cmd_decode.sv
module psr_cmd_decode
  import psr_pkg::*;
(
  input  logic [2:0]       cmd,
  output logic [PSR_W-1:0] set_vec,
  output logic [PSR_W-1:0] clr_vec
);
  flag_cmd_e op;

  always_comb begin
    op      = flag_cmd_e'(cmd);
    set_vec = '0;
    clr_vec = '0;
    case (op)
      CMD_SET_C: set_vec[BIT_C] = 1'b1;
      CMD_CLR_C: clr_vec[BIT_C] = 1'b1;
      CMD_SET_I: set_vec[BIT_I] = 1'b1;
      CMD_CLR_I: clr_vec[BIT_I] = 1'b1;
      CMD_SET_D: set_vec[BIT_D] = 1'b1;
      CMD_CLR_D: clr_vec[BIT_D] = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/psr_flag_bit.sv
module psr_flag_bit #(
  parameter bit HAS_RESET = 1'b1,
  parameter bit RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic load_en,
  input  logic load_val,
  input  logic force_set,
  input  logic cmd_set,
  input  logic cmd_clr,
  input  logic alu_en,
  input  logic alu_val,
  output logic q
);
  logic nxt;

  // priority: load, forced set, command set, command clear, ALU
  always_comb begin
    if (load_en)        nxt = load_val;
    else if (force_set) nxt = 1'b1;
    else if (cmd_set)   nxt = 1'b1;
    else if (cmd_clr)   nxt = 1'b0;
    else if (alu_en)    nxt = alu_val;
    else                nxt = q;
  end

  generate
    if (HAS_RESET) begin : g_rst
      always_ff @(posedge clk) begin
        if (rst) q <= RESET_VAL;
        else     q <= nxt;
      end
    end else begin : g_norst
      logic unused_rst;
      assign unused_rst = rst;
      always_ff @(posedge clk) q <= nxt;
    end
  endgenerate
endmodule

// File: rtl/psr_valid_track.sv
module psr_valid_track (
  input  logic clk,
  input  logic rst,
  input  logic load_en,
  input  logic result_upd,
  input  logic decimal_arith,
  output logic valid_q
);
  always_ff @(posedge clk) begin
    if (rst)             valid_q <= 1'b1;
    else if (load_en)    valid_q <= 1'b1;
    else if (result_upd) valid_q <= ~decimal_arith;
  end
endmodule

// File: rtl/psr_status_reg.sv
module psr_status_reg
  import psr_pkg::*;
#(
  parameter logic [1:0] RSVD_FILL = 2'b11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PSR_W-1:0] alu_we,
  input  logic [PSR_W-1:0] alu_flags,
  input  logic             alu_decimal_op,
  input  logic [2:0]       cmd,
  input  logic             int_accept,
  input  logic             load_en,
  input  logic [PSR_W-1:0] load_byte,
  input  logic             irq_req,
  input  logic             brk_req,
  output logic [PSR_W-1:0] status_byte,
  output logic             flag_c,
  output logic             flag_z,
  output logic             flag_i,
  output logic             flag_d,
  output logic             flag_v,
  output logic             flag_n,
  output logic             flags_valid,
  output logic             int_take
);
  logic [PSR_W-1:0] set_vec, clr_vec;
  logic [PSR_W-1:0] alu_en;
  logic             result_upd;
  logic             unused_in;

  psr_cmd_decode u_dec (
    .cmd     (cmd),
    .set_vec (set_vec),
    .clr_vec (clr_vec)
  );

  assign alu_en     = alu_we & ALU_MASK;
  assign result_upd = |(alu_we & RESULT_MASK);
  assign unused_in  = ^{alu_we[BIT_R_HI:BIT_I], load_byte[BIT_R_HI:BIT_R_LO]};

  generate
    for (genvar b = 0; b < PSR_W; b++) begin : g_bit
      if (b == BIT_R_LO || b == BIT_R_HI) begin : g_rsvd
        assign status_byte[b] = RSVD_FILL[b-BIT_R_LO];
      end else begin : g_flag
        psr_flag_bit #(
          .HAS_RESET (b != BIT_D),
          .RESET_VAL (b == BIT_I)
        ) u_bit (
          .clk       (clk),
          .rst       (rst),
          .load_en   (load_en),
          .load_val  (load_byte[b]),
          .force_set ((b == BIT_I) ? int_accept : 1'b0),
          .cmd_set   (set_vec[b]),
          .cmd_clr   (clr_vec[b]),
          .alu_en    (alu_en[b]),
          .alu_val   (alu_flags[b]),
          .q         (status_byte[b])
        );
      end
    end
  endgenerate

  psr_valid_track u_valid (
    .clk           (clk),
    .rst           (rst),
    .load_en       (load_en),
    .result_upd    (result_upd),
    .decimal_arith (alu_decimal_op & status_byte[BIT_D]),
    .valid_q       (flags_valid)
  );

  assign flag_c   = status_byte[BIT_C];
  assign flag_z   = status_byte[BIT_Z];
  assign flag_i   = status_byte[BIT_I];
  assign flag_d   = status_byte[BIT_D];
  assign flag_v   = status_byte[BIT_V];
  assign flag_n   = status_byte[BIT_N];
  assign int_take = brk_req | (irq_req & ~flag_i);

  // R2: decimal flag holds without load or decimal command
  a_r2_decimal_hold: assert property (@(posedge clk) disable iff (rst)
    (!load_en && cmd != CMD_SET_D && cmd != CMD_CLR_D) |=> $stable(flag_d));

  // R4: no update request leaves the byte unchanged
  a_r4_idle_stable: assert property (@(posedge clk) disable iff (rst)
    (alu_we == '0 && cmd == CMD_NONE && !int_accept && !load_en) |=> $stable(status_byte));

  // R6: carry command beats ALU carry
  a_r6_cmd_beats_alu: assert property (@(posedge clk) disable iff (rst)
    (!load_en && cmd == CMD_SET_C && alu_we[BIT_C] && !alu_flags[BIT_C]) |=> flag_c);

  // R7: accepted interrupt sets mask
  a_r7_accept_masks: assert property (@(posedge clk) disable iff (rst)
    (int_accept && !load_en) |=> flag_i);

  // R8: load copies all flag bits
  a_r8_load_copies: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (status_byte[BIT_N:BIT_V] == $past(load_byte[BIT_N:BIT_V]) &&
                 status_byte[BIT_D:BIT_C] == $past(load_byte[BIT_D:BIT_C]) && flags_valid));

  // R9: decimal arithmetic marks results invalid
  a_r9_decimal_invalid: assert property (@(posedge clk) disable iff (rst)
    (!load_en && alu_decimal_op && flag_d && (|(alu_we & RESULT_MASK))) |=> !flags_valid);
endmodule

// File: tb/tb_psr_status_reg.sv
`timescale 1ns/1ps
module tb_psr_status_reg;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] alu_we, alu_flags, load_byte;
  logic       alu_decimal_op, int_accept, load_en, irq_req, brk_req;
  logic [2:0] cmd;
  logic [7:0] status_byte;
  logic       flag_c, flag_z, flag_i, flag_d, flag_v, flag_n, flags_valid, int_take;

  int total = 0;
  int bad = 0;
  logic [7:0] exp_s = 8'h00;
  logic       exp_v = 1'b1;
  bit         d_known = 1'b0;

  always #2.5 clk = ~clk;

  psr_status_reg dut (
    .clk(clk), .rst(rst), .alu_we(alu_we), .alu_flags(alu_flags),
    .alu_decimal_op(alu_decimal_op), .cmd(cmd), .int_accept(int_accept),
    .load_en(load_en), .load_byte(load_byte), .irq_req(irq_req), .brk_req(brk_req),
    .status_byte(status_byte), .flag_c(flag_c), .flag_z(flag_z), .flag_i(flag_i),
    .flag_d(flag_d), .flag_v(flag_v), .flag_n(flag_n), .flags_valid(flags_valid),
    .int_take(int_take)
  );

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle();
    rst = 1'b0; alu_we = '0; alu_flags = '0; alu_decimal_op = 1'b0; cmd = 3'd0;
    int_accept = 1'b0; load_en = 1'b0; load_byte = '0;
  endtask

  // expected next state from the requirements, then one edge and compare
  task automatic step(input string req);
    logic [7:0] n;
    logic       nv;
    logic [7:0] m;
    n  = exp_s;
    nv = exp_v;
    if (rst) begin
      n[0] = 1'b0; n[1] = 1'b0; n[6] = 1'b0; n[7] = 1'b0; n[2] = 1'b1; nv = 1'b1;   // R1, R2
    end else if (load_en) begin
      n = load_byte; nv = 1'b1; d_known = 1'b1;                                  // R8
    end else begin
      if (alu_we[0]) n[0] = alu_flags[0];                                        // R4
      if (alu_we[1]) n[1] = alu_flags[1];
      if (alu_we[6]) n[6] = alu_flags[6];
      if (alu_we[7]) n[7] = alu_flags[7];
      case (cmd)                                                                 // R5, R6
        3'd1: n[0] = 1'b1;
        3'd2: n[0] = 1'b0;
        3'd3: n[2] = 1'b1;
        3'd4: n[2] = 1'b0;
        3'd5: begin n[3] = 1'b1; d_known = 1'b1; end
        3'd6: begin n[3] = 1'b0; d_known = 1'b1; end
        default: ;
      endcase
      if (int_accept) n[2] = 1'b1;                                               // R7
      if (alu_we[1] | alu_we[6] | alu_we[7]) nv = !(alu_decimal_op && exp_s[3]); // R9
    end
    n[5:4] = 2'b11;                                                              // R3
    exp_s = n;
    exp_v = nv;
    @(posedge clk);
    #1;
    m = d_known ? 8'hFF : 8'hF7;
    check((status_byte & m) == (n & m), req, status_byte, n);
    check(flags_valid == nv, {req, " R9 valid"}, {7'd0, flags_valid}, {7'd0, nv});
    check({flag_n, flag_v, flag_i, flag_z, flag_c} == {n[7], n[6], n[2], n[1], n[0]} &&
          (!d_known || flag_d == n[3]), "R11 flag lines",
          {flag_n, flag_v, 2'b00, flag_d, flag_i, flag_z, flag_c}, n);
    idle();
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    irq_req = 1'b0; brk_req = 1'b0;
    @(negedge clk);
    // R1: reset state
    rst = 1'b1; step("R1 reset");
    rst = 1'b1; step("R1 reset hold");
    check(status_byte[5:4] == 2'b11, "R3 reserved after reset", status_byte, 8'h30);
    // R2: decimal survives reset
    cmd = 3'd5; step("R5 set decimal");
    rst = 1'b1; step("R2 reset keeps D=1");
    cmd = 3'd6; step("R5 clear decimal");
    rst = 1'b1; step("R2 reset keeps D=0");

    // R4 R5 R6 R9 sweep over commands, enables and decimal state
    for (int d = 0; d < 2; d++) begin
      cmd = (d == 0) ? 3'd6 : 3'd5; step("R5 decimal select");
      for (int c = 0; c < 8; c++) begin
        for (int w = 0; w < 64; w++) begin
          alu_we = {w[3:2], w[5:4], w[4], w[5], w[1:0]};
          alu_flags = 8'((c * 64 + w) * 37 + 11);
          alu_decimal_op = w[0] ^ c[0];
          cmd = c[2:0];
          if (c == 5 || c == 6) cmd = 3'd0;
          step("R4 R5 R6 R9 sweep");
        end
      end
    end

    // R7: accept over mask clear
    cmd = 3'd4; int_accept = 1'b1; step("R7 accept over clear");
    cmd = 3'd4; step("R5 clear mask");
    int_accept = 1'b1; alu_we = 8'hFF; alu_flags = 8'h00; step("R7 accept with ALU");

    // R8 R3: every load byte, with competing requests
    for (int b = 0; b < 256; b++) begin
      load_en = 1'b1; load_byte = 8'(b);
      int_accept = b[0]; cmd = b[3:1]; alu_we = 8'hFF; alu_flags = ~8'(b);
      alu_decimal_op = 1'b1;
      step("R8 R3 load");
    end

    // R10: interrupt gate across mask, request and break
    for (int i = 0; i < 2; i++) begin
      cmd = (i == 0) ? 3'd4 : 3'd3; step("R5 mask select");
      for (int k = 0; k < 4; k++) begin
        irq_req = k[0]; brk_req = k[1];
        #1;
        check(int_take == (k[1] | (k[0] & (i == 0))), "R10 int gate",
              {7'd0, int_take}, {7'd0, k[1] | (k[0] & (i == 0))});
      end
      irq_req = 1'b0; brk_req = 1'b0;
      @(negedge clk);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule